// File: doc/BRIEF.md
# Inter-processor interrupt doorbell register

This block is one 32-bit register shared by a host core and a DSP core. Each core uses it to ring the other core and to learn when that core has finished servicing the request. Each core has its own synchronous write port: a write enable and a 32-bit data word. Each core also has its own read port. Both read ports show the current contents of the register, with no latency.

Each interrupt has two bits. The first is a trigger bit. A core writes 1 to it to fire the interrupt toward the peer, and it always reads back as 0. The second is a sticky flag placed 16 bits above the trigger. It becomes 1 when the interrupt fires and stays at 1 until some core writes 0 to it. The sender can therefore poll the flag to see when the receiver has cleared it.

The outputs are single-cycle pulses. The block drives four interrupt lines and one non-maskable interrupt line toward the DSP, and two interrupt lines toward the host.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset, both read ports return 0x00000000 and every interrupt output is low.
- R2: When the host port writes 1 to bit 0, `dsp_nmi` goes high for exactly one cycle, in the cycle after the write. Writing 1 to bit 4+k works the same way for `dsp_irq[k]`, for k = 0..3.
- R3: When the DSP port writes 1 to bit 12 or bit 13, `host_irq[0]` or `host_irq[1]` goes high for exactly one cycle, in the cycle after the write.
- R4: Trigger bits (0, 4..7, 12, 13) always read as 0. Writing 0 to a trigger bit fires nothing.
- R5: When a trigger bit fires, its flag at trigger position + 16 (bits 16, 20..23, 28, 29) reads 1 from the same cycle as the pulse. The flag stays 1 across later writes that put 1 in that position.
- R6: Writing 0 to a flag position clears only that flag. Flags written with 1 in the same word keep their value.
- R7: All other bit positions are reserved and always read 0, even after a write of all ones.
- R8: A trigger bit written by the port that does not own it is ignored: no pulse, and no flag change. The host port owns bits 0 and 4..7. The DSP port owns bits 12 and 13.
- R9: When a trigger and a 0 for its own flag arrive in the same cycle, the flag ends at 1.
- R10: When both ports write in the same cycle, each trigger bit is taken from its owning port. Each flag position follows the host port's written value.
- R11: The two read ports always return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host port write enable |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data |
| d_we | input | 1 | DSP port write enable |
| d_wdata | input | 32 | DSP port write data |
| d_rdata | output | 32 | DSP port read data |
| dsp_irq | output | 4 | Interrupt pulses toward the DSP |
| dsp_nmi | output | 1 | Non-maskable interrupt pulse toward the DSP |
| host_irq | output | 2 | Interrupt pulses toward the host |

## Verification
The bench uses several kinds of write:
- **Single-trigger and multi-trigger writes** separate a correct bit-to-line mapping from a shifted one.
- **An idle cycle after each write** confirms that a pulse lasts only one cycle.
- **Words with ones in the flag field** show that flags are sticky.
- **Words with isolated zeros in the flag field** show that clears reach one flag only.
- **Words that set and clear the same flag, and same-cycle writes from both ports**, show the set-wins rule and the host-priority rule.
- **All-ones writes from either port** confirm that reserved bits stay 0 and that non-owner triggers are ignored.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int REG_W      = 32;
    localparam int FLAG_OFS   = 16;
    localparam int N_DSP_IRQ  = 4;
    localparam int N_HOST_IRQ = 2;
    localparam int N_SLOT     = 1 + N_DSP_IRQ + N_HOST_IRQ;

    // slot order: 0 = DSP NMI, 1..4 = DSP irq 0..3, 5..6 = host irq 0..1
    function automatic int slot_pos(input int s);
        if (s == 0)              return 0;
        else if (s <= N_DSP_IRQ) return 3 + s;
        else                     return 12 + (s - N_DSP_IRQ - 1);
    endfunction

    function automatic bit slot_host_owned(input int s);
        return (s <= N_DSP_IRQ);
    endfunction

    typedef struct packed {
        logic pulse;
        logic flag;
    } bell_t;
endpackage

// File: rtl/ipi_port_merge.sv
module ipi_port_merge
    import ipi_pkg::*;
(
    input  logic             h_we,
    input  logic [REG_W-1:0] h_wdata,
    input  logic             d_we,
    input  logic [REG_W-1:0] d_wdata,
    output logic [N_SLOT-1:0] fire,
    output logic [N_SLOT-1:0] clr
);
    logic unused_bits;
    assign unused_bits = ^{h_wdata, d_wdata};

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        localparam int TPOS = slot_pos(s);
        localparam int FPOS = TPOS + FLAG_OFS;
        if (slot_host_owned(s)) begin : g_host
            assign fire[s] = h_we & h_wdata[TPOS];
        end else begin : g_dsp
            assign fire[s] = d_we & d_wdata[TPOS];
        end
        // flag write value: host wins when both ports write
        assign clr[s] = h_we ? ~h_wdata[FPOS] : (d_we & ~d_wdata[FPOS]);
    end
endmodule

// File: rtl/ipi_bell_slice.sv
module ipi_bell_slice
    import ipi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic pulse_o,
    output logic flag_o
);
    bell_t bell_d, bell_q;

    always_comb begin
        bell_d       = bell_q;
        bell_d.pulse = fire;
        bell_d.flag  = fire | (bell_q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bell_q <= '0;
        else        bell_q <= bell_d;
    end

    assign pulse_o = bell_q.pulse;
    assign flag_o  = bell_q.flag;

    p_pulse_after_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse_o);
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !pulse_o);
    p_flag_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_o);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> !flag_o);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr) |=> (flag_o && pulse_o));
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  h_we,
    input  logic [REG_W-1:0]      h_wdata,
    output logic [REG_W-1:0]      h_rdata,
    input  logic                  d_we,
    input  logic [REG_W-1:0]      d_wdata,
    output logic [REG_W-1:0]      d_rdata,
    output logic [N_DSP_IRQ-1:0]  dsp_irq,
    output logic                  dsp_nmi,
    output logic [N_HOST_IRQ-1:0] host_irq
);
    logic [N_SLOT-1:0] fire, clr, pulse, flag;
    logic [REG_W-1:0]  image;

    ipi_port_merge u_merge (
        .h_we    (h_we),
        .h_wdata (h_wdata),
        .d_we    (d_we),
        .d_wdata (d_wdata),
        .fire    (fire),
        .clr     (clr)
    );

    for (genvar s = 0; s < N_SLOT; s++) begin : g_bell
        ipi_bell_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (fire[s]),
            .clr     (clr[s]),
            .pulse_o (pulse[s]),
            .flag_o  (flag[s])
        );
    end

    always_comb begin
        image = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            image[slot_pos(s) + FLAG_OFS] = flag[s];
        end
    end

    assign h_rdata  = image;
    assign d_rdata  = image;
    assign dsp_nmi  = pulse[0];
    assign dsp_irq  = pulse[N_DSP_IRQ:1];
    assign host_irq = pulse[N_SLOT-1:N_DSP_IRQ+1];

    p_dsp_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !h_we |=> (dsp_irq == '0 && !dsp_nmi));
    p_host_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !d_we |=> (host_irq == '0));
    p_no_flag_from_nothing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_we && !d_we) |=> (h_rdata == $past(h_rdata)));
endmodule

// File: tb/tb_ipi_doorbell.sv
module tb_ipi_doorbell;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HOST_TRIG = 32'h0000_00F1;
    localparam logic [31:0] DSP_TRIG  = 32'h0000_3000;
    localparam logic [31:0] FLAG_MASK = 32'h30F1_0000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        h_we = 0, d_we = 0;
    logic [31:0] h_wdata = '0, d_wdata = '0;
    logic [31:0] h_rdata, d_rdata;
    logic [3:0]  dsp_irq;
    logic        dsp_nmi;
    logic [1:0]  host_irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [31:0] model_flags = '0;
    logic [6:0]  exp_p_q[$];
    logic [31:0] exp_r_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_doorbell dut (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .d_we(d_we), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .dsp_irq(dsp_irq), .dsp_nmi(dsp_nmi), .host_irq(host_irq)
    );

    task automatic compare(input logic [6:0] ep, input logic [31:0] er, input string tag);
        logic [6:0] ap;
        ap = {host_irq, dsp_irq, dsp_nmi};
        vectors++;
        if (ap !== ep || h_rdata !== er || d_rdata !== er) begin
            miscompares++;
            $display("FAIL %s: pulses=%b rd_host=%h rd_dsp=%h expected pulses=%b rd=%h",
                     tag, ap, h_rdata, d_rdata, ep, er);
        end
    endtask

    // driver: apply one write cycle, predict, push expectation
    task automatic drive(input logic hwe, input logic [31:0] hwd,
                         input logic dwe, input logic [31:0] dwd, input string tag);
        logic [31:0] trig, wv, clrm;
        @(negedge clk);
        h_we = hwe; h_wdata = hwd; d_we = dwe; d_wdata = dwd;
        trig = (hwe ? (hwd & HOST_TRIG) : 32'h0) | (dwe ? (dwd & DSP_TRIG) : 32'h0);
        wv   = hwe ? hwd : dwd;
        clrm = (hwe || dwe) ? (~wv & FLAG_MASK) : 32'h0;
        model_flags = (model_flags & ~clrm) | (trig << 16);
        @(posedge clk);
        exp_p_q.push_back({trig[13:12], trig[7:4], trig[0]});
        exp_r_q.push_back(model_flags);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 32'h0, 1'b0, 32'h0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_p_q.size() > 0) begin
            logic [6:0] ep;
            logic [31:0] er;
            string t;
            ep = exp_p_q.pop_front();
            er = exp_r_q.pop_front();
            t  = tag_q.pop_front();
            compare(ep, er, t);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare(7'b0, 32'h0, "R1 reset state");
        compare(7'b0, 32'h0, "R11 reset ports agree");

        drive(1, 32'h0000_0001, 0, 0, "R2 nmi trigger, R5 flag 16");
        idle("R2 nmi pulse one cycle");
        drive(1, 32'h0000_00F0, 0, 0, "R2 all dsp triggers");
        idle("R2 dsp pulses one cycle");
        drive(1, 32'hFFFF_0000, 0, 0, "R5 flags sticky, R4 zero trigger no effect");
        drive(0, 0, 1, 32'h0000_3000, "R3 host triggers");
        idle("R3 host pulses one cycle");
        drive(0, 0, 1, 32'hFFEF_0000, "R6 clear flag 20 only");
        drive(0, 0, 1, 32'hFFFF_00F1, "R8 dsp port on host triggers ignored");
        drive(1, 32'hFFFF_3000, 0, 0, "R8 host port on dsp triggers ignored");
        drive(1, 32'h0000_0010, 0, 0, "R9 trigger and clear same flag, set wins");
        drive(1, 32'h0000_0010, 0, 0, "R2 back-to-back trigger");
        drive(1, 32'hFFFF_0001, 1, 32'h0000_3000, "R10 both ports, host flag value kept");
        drive(1, 32'h0000_0000, 1, 32'hFFFF_0000, "R10 both ports, host clears all");
        drive(1, 32'hFFFF_FFFF, 0, 0, "R7 host all ones, reserved zero");
        drive(0, 0, 1, 32'hFFFF_FFFF, "R7 dsp all ones, reserved zero");
        drive(0, 0, 1, 32'hCFFF_0000, "R6 clear both host flags");
        drive(1, 32'hFF0F_0000, 0, 0, "R6 clear dsp irq flags, keep nmi flag");
        drive(1, 32'h0000_0000, 0, 0, "R4 zero write fires nothing, clears all");
        idle("R11 quiescent");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog R1..: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule